// File: doc/BRIEF.md
# Programmable Chip-Select Decoder with Wait-State Acknowledge

This block sits beside a bus master and turns each access address into chip-select strobes for a small set of memory or peripheral regions. Every channel holds a base register and an option register. The low three bits of the base register give the region size. The address bits at and above that size are compared against the base. The option register enables the channel and holds its wait-state count.

While the access strobe is high, every enabled channel whose region contains the address drives its chip select. The block then raises a transfer acknowledge once the programmed number of wait cycles has passed. When more than one channel claims the address, all of their selects are driven. The acknowledge follows the fastest of them. If their wait counts disagree, an overlap flag is raised so that misprogramming can be noticed. A simple write port loads the registers one at a time.

Top module: `csdec_top`

## Requirements
- R1: After synchronous active-low reset every channel is disabled, so `cs`, `ack` and `overlap` stay 0 even while the strobe is high.
- R2: Size code k (base bits [2:0], 0..7) gives a region of 2^(11+k) bytes. An address matches when its bits from 11+k upward equal the same bits of the base register. Bits below 11+k are ignored.
- R3: Base bits below the region size are ignored, so a base that is not aligned to its size matches the aligned block that contains it.
- R4: A channel whose enable bit (option bit 0) is 0 never drives its chip select, whatever the address.
- R5: `cs[i]` is 1 only while `bus_strb` is 1. All matching channels assert at the same time.
- R6: With wait count W (option bits [WSW:1]), `ack` rises exactly W rising clock edges after the strobe is first seen high. W=0 acknowledges in the same cycle as the strobe.
- R7: Once raised, `ack` stays high while the strobe stays high. It falls as soon as the strobe falls.
- R8: When matching channels carry different wait counts, `ack` follows the smallest count and `overlap` is 1 while the strobe is high.
- R9: When all matching channels carry the same wait count, `overlap` stays 0.
- R10: An address that no enabled channel matches produces no `cs`, no `ack` and no `overlap`.
- R11: A write with `reg_we`=1 loads `reg_wdata` into channel `reg_ch`. It goes to the base register when `reg_sel`=0 and to the option register when `reg_sel`=1. The new value takes effect from the next clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_ch | input | CHW | Channel index of the write |
| reg_sel | input | 1 | 0 = base register, 1 = option register |
| reg_wdata | input | AW | Write data |
| bus_strb | input | 1 | Access strobe, held high for the whole access |
| bus_addr | input | AW | Access address, stable while the strobe is high |
| cs | output | NCH | Chip select per channel, active high |
| ack | output | 1 | Transfer acknowledge |
| overlap | output | 1 | Matching channels disagree on wait count |

## Verification
The bench probes the last byte inside a region and the first byte past it. A decoder that is off by one size step, or that compares bits below the block size, would select on the wrong side of that edge. It programs a deliberately unaligned base and checks that the aligned block is decoded. A design that compared the raw base would miss the access. It measures the acknowledge edge cycle by cycle for zero and non-zero waits, where a stray register stage would shift it by one. It also overlaps two regions with unequal and then equal waits, which catches an acknowledge that follows the slower channel or an overlap flag that fires whenever two selects are active.

// File: rtl/csdec_pkg.sv
// Package: shared constants and the register-select encoding of the chip-select decoder.
// Assumes: regions start at 2 KB (2^11 bytes) and grow by powers of two.
package csdec_pkg;
    localparam int SIZE_LSB  = 11;   // log2 of the smallest region
    localparam int CODE_BITS = 3;    // width of the size code in the base register

    typedef enum logic {
        SEL_BASE = 1'b0,
        SEL_OPT  = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/csdec_regs.sv
// Module: register file holding base and option registers for every channel.
// Assumes: one write per cycle; reset leaves all channels disabled with zero waits.
module csdec_regs
    import csdec_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 24,
    parameter int WSW = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic [CHW-1:0]           reg_ch,
    input  logic                     reg_sel,
    input  logic [AW-1:0]            reg_wdata,
    output logic [NCH-1:0][AW-1:0]   base_q,
    output logic [NCH-1:0]           en_q,
    output logic [NCH-1:0][WSW-1:0]  wait_q
);
    // Per-channel storage: base register and the two option fields.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[c] <= '0;
                en_q[c]   <= 1'b0;
                wait_q[c] <= '0;
            end else if (reg_we && (int'(reg_ch) == c)) begin
                if (reg_sel == SEL_BASE) begin
                    base_q[c] <= reg_wdata;
                end else begin
                    en_q[c]   <= reg_wdata[0];
                    wait_q[c] <= reg_wdata[WSW:1];
                end
            end
        end
    end

    // R11: a write reaches exactly the addressed channel and register.
    p_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && reg_sel == SEL_OPT |=> en_q[$past(reg_ch)] == $past(reg_wdata[0]));
endmodule

// File: rtl/csdec_match.sv
// Module: address comparator for one channel, masked by the channel's size code.
// Assumes: AW is wide enough for the largest region (AW > SIZE_LSB + 7).
module csdec_match
    import csdec_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic          en,
    output logic          hit
);
    logic [CODE_BITS-1:0] code;
    logic [AW-1:0]        keep;

    // Build the compare mask: only bits at or above the region size count.
    always_comb begin
        code = base[CODE_BITS-1:0];
        for (int b = 0; b < AW; b++) begin
            keep[b] = (b >= SIZE_LSB + int'(code));
        end
    end

    // Channel hit: enabled and all kept bits equal.
    always_comb begin
        hit = en && (((addr ^ base) & keep) == '0);
    end
endmodule

// File: rtl/csdec_ack.sv
// Module: wait-state counter, smallest-wait selection and overlap detection.
// Assumes: address and register contents stay stable while the strobe is high.
module csdec_ack #(
    parameter int NCH = 4,
    parameter int WSW = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     strb,
    input  logic [NCH-1:0]           hit,
    input  logic [NCH-1:0][WSW-1:0]  wait_q,
    output logic                     ack,
    output logic                     overlap
);
    localparam logic [WSW-1:0] CNT_MAX = '1;

    logic [WSW-1:0] cnt;
    logic [WSW-1:0] wmin;
    logic [WSW-1:0] wmax;
    logic           any_hit;

    // Smallest and largest wait counts among hitting channels.
    always_comb begin
        wmin    = CNT_MAX;
        wmax    = '0;
        any_hit = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            if (hit[c]) begin
                any_hit = 1'b1;
                if (wait_q[c] < wmin) wmin = wait_q[c];
                if (wait_q[c] > wmax) wmax = wait_q[c];
            end
        end
    end

    // Count clock edges seen with the strobe high; saturate; clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !strb) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Outputs: acknowledge once enough edges passed; flag disagreeing waits.
    always_comb begin
        ack     = strb && any_hit && (cnt >= wmin);
        overlap = strb && any_hit && (wmin != wmax);
    end

    // R7: acknowledge persists until the strobe falls.
    p_ack_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack && strb |=> ack || !strb);
    // R6: a non-zero wait never acknowledges on the strobe's first cycle.
    p_no_early_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        strb && !$past(strb) && wmin != '0 |-> !ack);
    // R8: overlap needs at least two hitting channels.
    p_overlap_two_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overlap |-> $countones(hit) >= 2);
endmodule

// File: rtl/csdec_top.sv
// Module: chip-select decoder top; ties registers, per-channel comparators and ack logic.
// Assumes: bus_addr is stable for the whole strobe; registers are not rewritten mid-access.
module csdec_top #(
    parameter int NCH = 4,
    parameter int AW  = 24,
    parameter int WSW = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [CHW-1:0]  reg_ch,
    input  logic            reg_sel,
    input  logic [AW-1:0]   reg_wdata,
    input  logic            bus_strb,
    input  logic [AW-1:0]   bus_addr,
    output logic [NCH-1:0]  cs,
    output logic            ack,
    output logic            overlap
);
    logic [NCH-1:0][AW-1:0]  base_q;
    logic [NCH-1:0]          en_q;
    logic [NCH-1:0][WSW-1:0] wait_q;
    logic [NCH-1:0]          hit;

    csdec_regs #(.NCH(NCH), .AW(AW), .WSW(WSW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_ch(reg_ch),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .base_q(base_q), .en_q(en_q), .wait_q(wait_q)
    );

    // One comparator per channel.
    for (genvar c = 0; c < NCH; c++) begin : g_match
        csdec_match #(.AW(AW)) u_match (
            .addr(bus_addr), .base(base_q[c]), .en(en_q[c]), .hit(hit[c])
        );
        // R4: a disabled channel never selects.
        p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
            cs[c] |-> en_q[c]);
    end

    csdec_ack #(.NCH(NCH), .WSW(WSW)) u_ack (
        .clk(clk), .rst_n(rst_n), .strb(bus_strb), .hit(hit), .wait_q(wait_q),
        .ack(ack), .overlap(overlap)
    );

    // Chip selects: gate every hit with the strobe.
    always_comb begin
        cs = hit & {NCH{bus_strb}};
    end

    // R5: no chip select outside a strobe.
    p_cs_in_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs != '0 |-> bus_strb);
    // R10: acknowledge only when some channel is selected.
    p_ack_needs_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> cs != '0);
endmodule

// File: tb/sim_csdec_top.sv
// Directed bench for csdec_top: one task per scenario, each checking its own results.
module sim_csdec_top;
    localparam int NCH = 4;
    localparam int AW  = 24;
    localparam int WSW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_ch = '0;
    logic          reg_sel = 1'b0;
    logic [AW-1:0] reg_wdata = '0;
    logic          bus_strb = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [NCH-1:0] cs;
    logic          ack;
    logic          overlap;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    csdec_top #(.NCH(NCH), .AW(AW), .WSW(WSW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_ch(reg_ch),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .bus_strb(bus_strb),
        .bus_addr(bus_addr), .cs(cs), .ack(ack), .overlap(overlap)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int ch, input bit sel, input int data);
        @(negedge clk);
        reg_we = 1'b1; reg_ch = 2'(ch); reg_sel = sel; reg_wdata = AW'(data);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // One access: exp_w < 0 means no acknowledge is expected at all.
    task automatic access(input string req, input int addr, input int exp_cs,
                          input int exp_w, input bit exp_ovl);
        int last;
        last = (exp_w < 0) ? 3 : exp_w + 2;
        @(negedge clk);
        bus_addr = AW'(addr); bus_strb = 1'b1;
        #1;
        check({req, " cs"}, int'(cs), exp_cs);
        check({req, " overlap"}, int'(overlap), int'(exp_ovl));
        for (int k = 0; k <= last; k++) begin
            if (k > 0) begin
                @(negedge clk); #1;
            end
            check({req, " ack timing R6 R7"}, int'(ack), (exp_w >= 0 && k >= exp_w) ? 1 : 0);
        end
        @(negedge clk);
        bus_strb = 1'b0;
        #1;
        check({req, " release R5 R7"}, int'({cs, ack, overlap}), 0);
    endtask

    task automatic t_reset;
        access("R1 reset", 'h000000, 0, -1, 0);
    endtask

    task automatic t_size_edges;
        wr(0, 0, 'h010000);                 // 2 KB region
        wr(0, 1, (2 << 1) | 1);             // wait 2, enabled
        access("R2 last byte in", 'h0107FF, 'b0001, 2, 0);
        access("R2 R10 first byte out", 'h010800, 0, -1, 0);
    endtask

    task automatic t_unaligned;
        wr(1, 0, 'h022003);                 // 16 KB, base not aligned
        wr(1, 1, 1);                        // wait 0
        access("R3 aligned block", 'h020010, 'b0010, 0, 0);
        access("R3 past block", 'h024000, 0, -1, 0);
    endtask

    task automatic t_disable;
        wr(2, 0, 'h030000);
        wr(2, 1, 3 << 1);                   // wait 3, disabled
        access("R4 disabled", 'h030004, 0, -1, 0);
        wr(2, 1, (3 << 1) | 1);
        access("R11 enable write", 'h030004, 'b0100, 3, 0);
    endtask

    task automatic t_idle_strobe;
        @(negedge clk);
        bus_addr = 'h030004; bus_strb = 1'b0;
        #1;
        check("R5 no strobe", int'({cs, ack}), 0);
    endtask

    task automatic t_overlap;
        wr(3, 0, 'h000007);                 // 256 KB from 0
        wr(3, 1, (5 << 1) | 1);             // wait 5
        access("R8 unequal waits", 'h0107FF, 'b1001, 2, 1);
        wr(0, 1, (5 << 1) | 1);             // same wait as channel 3
        access("R9 equal waits", 'h010000, 'b1001, 5, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_size_edges();
        t_unaligned();
        t_disable();
        t_idle_strobe();
        t_overlap();
        done = 1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule